// File: doc/BRIEF.md
# PWM-Aligned Modulator Clock Starter

This block derives the bit clock for an external sigma-delta modulator from the system clock through a programmable integer divider. The modulator clock does not start when the block is enabled. The block first waits for a PWM synchronisation edge, then counts a programmable number of system clocks, and only then starts the divider. When the wait is set to half the sinc impulse-response length, the centre tap of the filter falls on the PWM sync instant. Software cannot use a negative delay to get this alignment, but a delay of this length has the same effect.

After the first edge the modulator clock runs freely and is never re-timed. It stays in step with the PWM provided the PWM period holds a whole number of decimated samples, that is f_mod = f_pwm × D × software decimation (for example 10 MHz = 16 kHz × 125 × 5). Beside the clock, the block marks every modulator rising edge, every D-th rising edge (one primary decimated sample) and every (PCNT+1)-th decimated sample (the data-ready event). For a third-order filter the recommended wait is MDIV·(3·D − 2)/2 system clocks.

Top module: `modclk_starter`

## Requirements
- R1: While reset is high, and in the first cycle after it, all five outputs are low.
- R2: While running, mod_clk repeats with a period of MDIV system clocks. It is high for floor(MDIV/2) cycles and then low for the rest of the period, giving a 50% duty cycle for even MDIV. MDIV values 0 and 1 act as 2. mod_clk is low whenever running is low.
- R3: mod_clk_en is high for exactly one system clock, in the first high cycle of every modulator period, and never otherwise.
- R4: While armed and waiting, a pwm_sync rising edge sampled at system clock edge t starts the clock at edge t+DELAY. At that edge running rises and the first mod_clk high cycle, with mod_clk_en, begins. A DELAY of 0 starts the clock at edge t.
- R5: Only a pwm_sync rising edge seen while armed and waiting has any effect. Sync edges before arming have no effect. Sync edges during the delay or while running have no effect. A sync level held high counts as one edge. Once started, the clock phase is never changed by later sync edges.
- R6: dec_strobe coincides with mod_clk_en on the D-th modulator rising edge after start and on every D-th one after it. A D of 0 acts as 1.
- R7: data_irq coincides with dec_strobe on every (PCNT+1)-th strobe, the first on the (PCNT+1)-th.
- R8: When arm is low at a clock edge, all outputs are low from that edge onward and the block returns to idle. A restart then needs arm high again followed by a new sync edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Enable; low forces idle |
| pwm_sync | input | 1 | PWM synchronisation pulse or level, rising edge used |
| mdiv | input | DIV_W | System clocks per modulator period |
| dec_ratio | input | DEC_W | Modulator edges per decimated sample (D) |
| pcnt | input | CNT_W | Decimated samples per data-ready event, minus one |
| start_dly | input | DLY_W | System clocks from sync edge to clock start |
| mod_clk | output | 1 | Modulator clock |
| mod_clk_en | output | 1 | One-cycle mark of each modulator rising edge |
| dec_strobe | output | 1 | Decimated-sample strobe |
| data_irq | output | 1 | Data-ready event |
| running | output | 1 | Modulator clock is active |

## Verification
The assertions check the cycle-local rules on every cycle:
- the edge mark falls only on a low-to-high step of the clock, and only while running;
- the strobe is a subset of the edge marks, and the data-ready event is a subset of the strobes;
- a running clock keeps running while armed;
- disarming clears everything at the next edge.

The exact start cycle after the sync edge, the divider period and duty, and the D and PCNT+1 counting can only be shown by the bench's scenarios. These compare each output cycle by cycle against an arithmetic model across random and corner settings, including syncs injected mid-run and syncs sent while disarmed.

// File: rtl/modclk_pkg.sv
package modclk_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_DELAY = 2'd2,
    ST_RUN   = 2'd3
  } mc_state_t;
endpackage

// File: rtl/modclk_seq.sv
module modclk_seq
  import modclk_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             pwm_sync,
  input  logic [DLY_W-1:0] start_dly,
  output logic             start_now,
  output logic             run_next,
  output logic             running
);
  mc_state_t        state, nxt;
  logic             sync_q;
  logic             sync_evt;
  logic [DLY_W-1:0] dly_cnt;

  assign sync_evt = pwm_sync & ~sync_q;

  always_comb begin
    nxt       = state;
    start_now = 1'b0;
    case (state)
      ST_IDLE:  if (arm) nxt = ST_ARMED;
      ST_ARMED: if (sync_evt) begin
        if (start_dly == '0) begin
          nxt       = ST_RUN;
          start_now = 1'b1;
        end else begin
          nxt = ST_DELAY;
        end
      end
      ST_DELAY: if (dly_cnt == DLY_W'(1)) begin
        nxt       = ST_RUN;
        start_now = 1'b1;
      end
      default: nxt = state;
    endcase
    if (!arm) begin
      nxt       = ST_IDLE;
      start_now = 1'b0;
    end
  end

  assign run_next = (nxt == ST_RUN);
  assign running  = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      sync_q  <= 1'b0;
      dly_cnt <= '0;
    end else begin
      state  <= nxt;
      sync_q <= pwm_sync;
      if (state == ST_ARMED && sync_evt)
        dly_cnt <= start_dly;
      else if (state == ST_DELAY)
        dly_cnt <= dly_cnt - DLY_W'(1);
    end
  end
endmodule

// File: rtl/modclk_div.sv
module modclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] mdiv,
  input  logic             start,
  input  logic             run_next,
  output logic             mod_clk,
  output logic             mod_clk_en,
  output logic             rise_nxt
);
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [DIV_W-1:0] eff, half, ph, nph;

  assign eff      = (mdiv < MIN_DIV) ? MIN_DIV : mdiv;
  assign half     = eff >> 1;
  assign nph      = (ph == eff - DIV_W'(1)) ? '0 : ph + DIV_W'(1);
  assign rise_nxt = run_next & (start | (nph == '0));

  always_ff @(posedge clk) begin
    if (rst || !run_next) begin
      ph         <= '0;
      mod_clk    <= 1'b0;
      mod_clk_en <= 1'b0;
    end else if (start) begin
      ph         <= '0;
      mod_clk    <= 1'b1;
      mod_clk_en <= 1'b1;
    end else begin
      ph         <= nph;
      mod_clk    <= (nph < half);
      mod_clk_en <= (nph == '0);
    end
  end
endmodule

// File: rtl/modclk_evcnt.sv
module modclk_evcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         pulse,
  output logic         wrap_nxt
);
  logic [W-1:0] cnt;

  assign wrap_nxt = ~clr & tick & (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= wrap_nxt;
      if (tick) cnt <= (cnt == limit) ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/modclk_starter.sv
module modclk_starter #(
  parameter int DIV_W = 8,
  parameter int DEC_W = 8,
  parameter int CNT_W = 8,
  parameter int DLY_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             pwm_sync,
  input  logic [DIV_W-1:0] mdiv,
  input  logic [DEC_W-1:0] dec_ratio,
  input  logic [CNT_W-1:0] pcnt,
  input  logic [DLY_W-1:0] start_dly,
  output logic             mod_clk,
  output logic             mod_clk_en,
  output logic             dec_strobe,
  output logic             data_irq,
  output logic             running
);
  logic             start_now, run_next, rise_nxt;
  logic             dec_wrap, irq_wrap_unused;
  logic [DEC_W-1:0] dec_eff, dec_lim;

  assign dec_eff = (dec_ratio == '0) ? DEC_W'(1) : dec_ratio;
  assign dec_lim = dec_eff - DEC_W'(1);

  modclk_seq #(.DLY_W(DLY_W)) u_seq (
    .clk(clk), .rst(rst), .arm(arm), .pwm_sync(pwm_sync),
    .start_dly(start_dly), .start_now(start_now),
    .run_next(run_next), .running(running)
  );

  modclk_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .mdiv(mdiv), .start(start_now),
    .run_next(run_next), .mod_clk(mod_clk),
    .mod_clk_en(mod_clk_en), .rise_nxt(rise_nxt)
  );

  modclk_evcnt #(.W(DEC_W)) u_dec (
    .clk(clk), .rst(rst), .clr(~run_next), .tick(rise_nxt),
    .limit(dec_lim), .pulse(dec_strobe), .wrap_nxt(dec_wrap)
  );

  modclk_evcnt #(.W(CNT_W)) u_irq (
    .clk(clk), .rst(rst), .clr(~run_next), .tick(dec_wrap),
    .limit(pcnt), .pulse(data_irq), .wrap_nxt(irq_wrap_unused)
  );
endmodule

// File: rtl/modclk_starter_chk.sv
module modclk_starter_chk (
  input logic clk,
  input logic rst,
  input logic arm,
  input logic mod_clk,
  input logic mod_clk_en,
  input logic dec_strobe,
  input logic data_irq,
  input logic running
);
  AST_EN_WHILE_RUN: assert property (@(posedge clk) disable iff (rst)
    mod_clk_en |-> (running && mod_clk)); // R3
  AST_EN_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    mod_clk_en |-> !$past(mod_clk)); // R3
  AST_CLK_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    mod_clk |-> running); // R2
  AST_START_WITH_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> mod_clk_en); // R4
  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (running && arm) |=> running); // R5
  AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    dec_strobe |-> mod_clk_en); // R6
  AST_IRQ_ON_STROBE: assert property (@(posedge clk) disable iff (rst)
    data_irq |-> dec_strobe); // R7
  AST_DISARM_STOPS: assert property (@(posedge clk) disable iff (rst)
    !arm |=> (!running && !mod_clk && !mod_clk_en)); // R8
endmodule

bind modclk_starter modclk_starter_chk u_chk (
  .clk(clk), .rst(rst), .arm(arm), .mod_clk(mod_clk),
  .mod_clk_en(mod_clk_en), .dec_strobe(dec_strobe),
  .data_irq(data_irq), .running(running)
);

// File: tb/modclk_starter_bench.sv
module modclk_starter_bench;
  localparam int CLK_NS = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        arm = 1'b0;
  logic        pwm_sync = 1'b0;
  logic [7:0]  mdiv = 8'd2;
  logic [7:0]  dec_ratio = 8'd1;
  logic [7:0]  pcnt = 8'd0;
  logic [15:0] start_dly = 16'd0;
  logic mod_clk, mod_clk_en, dec_strobe, data_irq, running;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS / 2.0) clk = ~clk;

  modclk_starter u_modclk_starter (
    .clk(clk), .rst(rst), .arm(arm), .pwm_sync(pwm_sync),
    .mdiv(mdiv), .dec_ratio(dec_ratio), .pcnt(pcnt), .start_dly(start_dly),
    .mod_clk(mod_clk), .mod_clk_en(mod_clk_en), .dec_strobe(dec_strobe),
    .data_irq(data_irq), .running(running)
  );

  function automatic int eff_m(int m);
    return (m < 2) ? 2 : m;
  endfunction

  function automatic int eff_d(int d);
    return (d == 0) ? 1 : d;
  endfunction

  // {running, mod_clk, mod_clk_en, dec_strobe, data_irq} k cycles after start
  function automatic logic [4:0] model(int k, int m, int d, int p);
    int mm = eff_m(m);
    int dd = eff_d(d);
    int ph = k % mm;
    int cyc = k / mm;
    logic en = (ph == 0);
    logic st = en && (((cyc + 1) % dd) == 0);
    logic iq = en && (((cyc + 1) % (dd * (p + 1))) == 0);
    return {1'b1, (ph < mm / 2), en, st, iq};
  endfunction

  function automatic logic [4:0] outs();
    return {running, mod_clk, mod_clk_en, dec_strobe, data_irq};
  endfunction

  task automatic chk(string req, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one armed start, run for nrun cycles, inject syncs mid-run, then disarm
  task automatic run_case(int m, int d, int p, int dly, int nrun, bit held);
    mdiv = 8'(m); dec_ratio = 8'(d); pcnt = 8'(p); start_dly = 16'(dly);
    // R5: sync before arming has no effect
    pwm_sync = 1'b1; step(); pwm_sync = 1'b0; step();
    chk("R5 pre-arm sync", outs(), 5'b0);
    arm = 1'b1; step(); step(); step();
    chk("R5 pre-arm sync after arm", outs(), 5'b0);
    pwm_sync = 1'b1;
    for (int i = 0; i < dly; i++) begin
      step();
      if (!held) pwm_sync = 1'b0;
      if (i == dly / 2) pwm_sync = 1'b1;  // R5: sync during delay ignored
      else if (!held) pwm_sync = 1'b0;
      chk("R4 delay idle", outs(), 5'b0);
    end
    for (int k = 0; k < nrun; k++) begin
      step();
      if (!held) pwm_sync = 1'b0;
      chk((k == 0) ? "R4 start edge" : "R2 R3 R6 R7 run", outs(), model(k, m, d, p));
      if (k % 7 == 3) pwm_sync = 1'b1;    // R5: sync while running ignored
    end
    pwm_sync = 1'b0;
    arm = 1'b0;
    step();
    chk("R8 disarm stop", outs(), 5'b0);
    pwm_sync = 1'b1; step(); pwm_sync = 1'b0; step(); step();
    chk("R8 idle after disarm", outs(), 5'b0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: outputs %b expected completion", outs());
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1729));
    @(negedge clk);
    chk("R1 in reset", outs(), 5'b0);
    step(); step();
    rst = 1'b0;
    step();
    chk("R1 after reset", outs(), 5'b0);

    // directed corners
    run_case(2, 3, 1, 0, 40, 1'b0);                 // zero delay
    run_case(8, 4, 2, 8 * (3 * 4 - 2) / 2, 300, 1'b0); // half impulse length
    run_case(3, 2, 0, 5, 60, 1'b0);                 // odd divider
    run_case(0, 0, 0, 1, 20, 1'b0);                 // R2 mdiv 0 as 2, R6 D 0 as 1
    run_case(1, 2, 3, 7, 40, 1'b1);                 // mdiv 1, held sync level

    for (int t = 0; t < 8; t++) begin
      int m = 2 + int'($urandom_range(0, 7));
      int d = 1 + int'($urandom_range(0, 4));
      int p = int'($urandom_range(0, 3));
      int dl = ($urandom_range(0, 1) == 1) ? (m * (3 * d - 2)) / 2
                                            : int'($urandom_range(0, 40));
      run_case(m, d, p, dl, 2 * eff_m(m) * d * (p + 1) + 5, 1'b0);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule